// File: doc/BRIEF.md
# Multi-Header Uncorrectable Error Logger

This block holds the logging side of an advanced error reporting capability for uncorrectable errors. Each error event brings one status bit, a four-dword packet header, an optional four-dword packet prefix, and flags that say whether the header is valid and whether a prefix is present. For the error that counts as "first", the block keeps a first-error index, a header log and a prefix log. When multiple-header recording is enabled, errors that arrive while that first error is still pending wait in a small FIFO.

The register file that holds the uncorrectable status register stays outside the block. It sends in the status value after every write to the capability, together with a write strobe. The block sends back a vector of status bits that the register file must set again. On its own side, the register file sets the status bit of every accepted event. A full FIFO turns a further queued error into a one-cycle request for a correctable header-log-overflow error.

All outputs are registered. The result of an input applied before a clock edge appears after that edge.

Top module: `aer_hdr_logger`

## Requirements
- R1: An event is ignored unless `ev_status` ANDed with the supported mask (bits 4, 5 and 12 to 21 by default) has exactly one bit set. An ignored event changes no log field and no queue entry.
- R2: A logged error loads `fep` with the bit index of its single masked status bit.
- R3: A logged error with `ev_hdr_ok` high stores header dword i (bits 32i+31:32i) into `hdr_log` byte-swapped. The dword's bits 31:24 go to `hdr_log` bits 32i+7:32i, and so on down to its bits 7:0, which go to bits 32i+31:32i+24. With `ev_hdr_ok` low, `hdr_log` becomes zero.
- R4: The prefix log takes the prefix with the same byte swap, and `pfx_flag` is set, only when `ev_pfx_ok` and `pfx_cap` are both high as the entry is loaded. Otherwise `pfx_log` is zero and `pfx_flag` is low.
- R5: A valid event is queued instead of logged when `multi_en` is high and `unc_status[fep]` is set. If the FIFO already holds DEPTH entries, the event is dropped and `hlo_req` is raised.
- R6: A write (`cap_wr`) with `unc_status[fep]` clear, when `multi_en` is low or the FIFO is empty, clears `fep`, `pfx_flag`, `hdr_log` and `pfx_log`.
- R7: A write with `unc_status[fep]` clear, `multi_en` high and the FIFO not empty pops the oldest entry into the logs. In the next cycle `status_set` carries the status bits of every entry that was queued before the pop.
- R8: A write with `unc_status[fep]` set and `multi_en` high leaves the logs alone. In the next cycle `status_set` carries the status bits of all queued entries.
- R9: A write with `unc_status[fep]` set and `multi_en` low discards every queued entry.
- R10: When a write and a valid event share a cycle, the write is applied first and the event sees the result. After a pop the event is queued. After a clear it is logged.
- R11: A synchronous reset empties the FIFO and clears all log fields, `status_set` and `hlo_req`.
- R12: `hlo_req` and `status_set` are single-cycle outputs. Each is zero in any cycle that does not follow its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Error event strobe |
| ev_status | input | W | Status bit of the event |
| ev_hdr | input | 128 | Packet header, dword 0 in bits 31:0 |
| ev_pfx | input | 128 | Packet prefix, dword 0 in bits 31:0 |
| ev_hdr_ok | input | 1 | Header is valid |
| ev_pfx_ok | input | 1 | Prefix is present |
| multi_en | input | 1 | Multiple-header recording enable |
| pfx_cap | input | 1 | End-to-end prefix support is advertised |
| cap_wr | input | 1 | Software wrote the capability this cycle |
| unc_status | input | W | Uncorrectable status after the write |
| fep | output | log2(W) | First-error index |
| pfx_flag | output | 1 | Prefix log holds a prefix |
| hdr_log | output | 128 | Header log, byte k in bits 8k+7:8k |
| pfx_log | output | 128 | Prefix log, byte k in bits 8k+7:8k |
| status_set | output | W | Status bits to set again, one cycle |
| hlo_req | output | 1 | Header-log-overflow request, one cycle |

## Verification
A software write and a new error event can land in the same cycle. That is the case where a pop, a clear or a flush competes with a fresh log load or a push. The bench forces it in directed form: a write that clears the pending bit while an event arrives, once with a non-empty queue and once with an empty one. In the random phase both strobes are drawn independently, so the pair occurs often. The bench's reference applies the write before the event, and every output of the following cycle is compared with that reference.

// File: rtl/aer_hdr_logger.sv
module aer_hdr_logger #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  parameter logic [W-1:0] UNC_MASK = 32'h003F_F030,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [W-1:0]  ev_status,
  input  logic [127:0]  ev_hdr,
  input  logic [127:0]  ev_pfx,
  input  logic          ev_hdr_ok,
  input  logic          ev_pfx_ok,
  input  logic          multi_en,
  input  logic          pfx_cap,
  input  logic          cap_wr,
  input  logic [W-1:0]  unc_status,
  output logic [IW-1:0] fep,
  output logic          pfx_flag,
  output logic [127:0]  hdr_log,
  output logic [127:0]  pfx_log,
  output logic [W-1:0]  status_set,
  output logic          hlo_req
);

  function automatic logic [IW-1:0] enc(input logic [W-1:0] v);
    enc = '0;
    for (int i = 0; i < W; i++) if (v[i]) enc = IW'(i);
  endfunction

  function automatic logic [127:0] bswap(input logic [127:0] d);
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        bswap[32*w + 8*b +: 8] = d[32*w + 24 - 8*b +: 8];
  endfunction

  logic [IW-1:0] q_idx [DEPTH];
  logic          q_hv  [DEPTH];
  logic          q_pv  [DEPTH];
  logic [127:0]  q_h   [DEPTH];
  logic [127:0]  q_p   [DEPTH];
  logic [CW-1:0] cnt;

  logic [W-1:0] ev_m, qbits;
  logic ev_ok, first_set, pop, clr, flush, go_q, go_log, full, push;
  logic [CW-1:0] cnt_p;
  logic [AW-1:0] wptr;

  assign ev_m      = ev_status & UNC_MASK;
  assign ev_ok     = ev_valid && (ev_m != '0) && ((ev_m & (ev_m - 1'b1)) == '0);
  assign first_set = unc_status[fep];
  assign pop       = cap_wr && !first_set && multi_en && (cnt != '0);
  assign clr       = cap_wr && !first_set && !pop;
  assign flush     = cap_wr && first_set && !multi_en;
  assign go_q      = ev_ok && multi_en && (first_set || pop);
  assign go_log    = ev_ok && !go_q;
  assign cnt_p     = cnt - CW'(pop);
  assign full      = (cnt_p == CW'(DEPTH));
  assign push      = go_q && !full;
  assign wptr      = cnt_p[AW-1:0];

  always_comb begin
    qbits = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CW'(k) < cnt) qbits[q_idx[k]] = 1'b1;
  end

  logic [IW-1:0] ld_idx;
  logic          ld_hv, ld_pv;
  logic [127:0]  ld_h, ld_p;
  assign ld_idx = pop ? q_idx[0] : enc(ev_m);
  assign ld_hv  = pop ? q_hv[0]  : ev_hdr_ok;
  assign ld_pv  = pop ? q_pv[0]  : ev_pfx_ok;
  assign ld_h   = pop ? q_h[0]   : ev_hdr;
  assign ld_p   = pop ? q_p[0]   : ev_pfx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      fep        <= '0;
      pfx_flag   <= 1'b0;
      hdr_log    <= '0;
      pfx_log    <= '0;
      status_set <= '0;
      hlo_req    <= 1'b0;
    end else begin
      hlo_req    <= go_q && full;
      status_set <= (cap_wr && multi_en && (first_set || cnt != '0)) ? qbits : '0;

      if (flush) begin
        cnt <= '0;
      end else begin
        if (pop)
          for (int k = 0; k < DEPTH - 1; k++) begin
            q_idx[k] <= q_idx[k+1];
            q_hv[k]  <= q_hv[k+1];
            q_pv[k]  <= q_pv[k+1];
            q_h[k]   <= q_h[k+1];
            q_p[k]   <= q_p[k+1];
          end
        if (push) begin
          q_idx[wptr] <= enc(ev_m);
          q_hv[wptr]  <= ev_hdr_ok;
          q_pv[wptr]  <= ev_pfx_ok;
          q_h[wptr]   <= ev_hdr;
          q_p[wptr]   <= ev_pfx;
        end
        cnt <= cnt_p + CW'(push);
      end

      if (pop || go_log) begin
        fep      <= ld_idx;
        hdr_log  <= ld_hv ? bswap(ld_h) : '0;
        pfx_flag <= ld_pv && pfx_cap;
        pfx_log  <= (ld_pv && pfx_cap) ? bswap(ld_p) : '0;
      end else if (clr) begin
        fep      <= '0;
        pfx_flag <= 1'b0;
        hdr_log  <= '0;
        pfx_log  <= '0;
      end
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_ovf_full_r5: assert property (@(posedge clk) disable iff (rst)
    hlo_req |-> $past(cnt) == CW'(DEPTH));
  p_reject_r1: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ok && !cap_wr) |=> ($stable(fep) && $stable(hdr_log) && $stable(cnt)));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !go_log) |=> (fep == '0 && !pfx_flag && hdr_log == '0 && pfx_log == '0));
  p_pfx_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pfx_flag) |-> $past(pfx_cap));
  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> cnt == '0);
  p_ovf_cause_r12: assert property (@(posedge clk) disable iff (rst)
    hlo_req |-> $past(ev_valid));

endmodule

// File: tb/aer_hdr_logger_test.sv
module aer_hdr_logger_test;
  localparam int W = 32;
  localparam int DEPTH = 4;
  localparam logic [31:0] MASK = 32'h003F_F030;

  logic clk = 0, rst = 1;
  logic ev_valid = 0, ev_hdr_ok = 0, ev_pfx_ok = 0, multi_en = 0, pfx_cap = 0, cap_wr = 0;
  logic [31:0] ev_status = '0, unc_status = '0;
  logic [127:0] ev_hdr = '0, ev_pfx = '0;
  logic [4:0] fep;
  logic pfx_flag, hlo_req;
  logic [127:0] hdr_log, pfx_log;
  logic [31:0] status_set;

  aer_hdr_logger uut (.clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_status(ev_status),
    .ev_hdr(ev_hdr), .ev_pfx(ev_pfx), .ev_hdr_ok(ev_hdr_ok), .ev_pfx_ok(ev_pfx_ok),
    .multi_en(multi_en), .pfx_cap(pfx_cap), .cap_wr(cap_wr), .unc_status(unc_status),
    .fep(fep), .pfx_flag(pfx_flag), .hdr_log(hdr_log), .pfx_log(pfx_log),
    .status_set(status_set), .hlo_req(hlo_req));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] sts = '0;
  logic [4:0] mq_idx [DEPTH];
  logic mq_hv [DEPTH], mq_pv [DEPTH];
  logic [127:0] mq_h [DEPTH], mq_p [DEPTH];
  int mcnt = 0;
  logic [4:0] e_fep = '0;
  logic e_pb = 0, e_ovf = 0;
  logic [127:0] e_hdr = '0, e_pfx = '0;
  logic [31:0] e_reas = '0;

  function automatic logic [127:0] bsw(input logic [127:0] d);
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        bsw[32*w + 8*b +: 8] = d[32*w + 24 - 8*b +: 8];
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_load(logic [4:0] i, logic hv, logic [127:0] h, logic pv, logic [127:0] p);
    e_fep = i;
    e_hdr = hv ? bsw(h) : '0;
    e_pb  = pv && pfx_cap;
    e_pfx = (pv && pfx_cap) ? bsw(p) : '0;
  endtask

  task automatic step(string tag, logic v, logic [31:0] st, logic hv, logic pv,
                      logic me, logic pc, logic wr, logic [31:0] clrbits);
    logic [31:0] evm, qb;
    logic ok, fs, pop, clr, fl, goq, full;
    logic [4:0] idx;
    logic [127:0] h, p;
    int cp;
    @(negedge clk);
    h = r128(); p = r128();
    ev_valid = v; ev_status = st; ev_hdr = h; ev_pfx = p; ev_hdr_ok = hv; ev_pfx_ok = pv;
    multi_en = me; pfx_cap = pc; cap_wr = wr;
    unc_status = wr ? (sts & ~clrbits) : sts;
    evm = st & MASK;
    ok = v && evm != 0 && (evm & (evm - 1)) == 0;
    idx = '0;
    for (int i = 0; i < 32; i++) if (evm[i]) idx = 5'(i);
    fs  = unc_status[e_fep];
    pop = wr && !fs && me && mcnt != 0;
    clr = wr && !fs && !pop;
    fl  = wr && fs && !me;
    qb = '0;
    for (int k = 0; k < mcnt; k++) qb[mq_idx[k]] = 1'b1;
    e_reas = (wr && me && (fs || mcnt != 0)) ? qb : '0;
    goq = ok && me && (fs || pop);
    cp = mcnt - (pop ? 1 : 0);
    full = (cp == DEPTH);
    e_ovf = goq && full;
    if (pop) model_load(mq_idx[0], mq_hv[0], mq_h[0], mq_pv[0], mq_p[0]);
    else if (ok && !goq) model_load(idx, hv, h, pv, p);
    else if (clr) begin e_fep = '0; e_hdr = '0; e_pfx = '0; e_pb = 0; end
    if (fl) mcnt = 0;
    else begin
      if (pop)
        for (int k = 0; k < DEPTH - 1; k++) begin
          mq_idx[k] = mq_idx[k+1]; mq_hv[k] = mq_hv[k+1]; mq_pv[k] = mq_pv[k+1];
          mq_h[k] = mq_h[k+1]; mq_p[k] = mq_p[k+1];
        end
      if (goq && !full) begin
        mq_idx[cp] = idx; mq_hv[cp] = hv; mq_pv[cp] = pv; mq_h[cp] = h; mq_p[cp] = p;
        cp++;
      end
      mcnt = cp;
    end
    sts = unc_status | (ok ? evm : 32'h0) | e_reas;
    @(posedge clk); #1;
    chk({tag, " R2 fep"}, 128'(fep), 128'(e_fep));
    chk({tag, " R3 hdr_log"}, hdr_log, e_hdr);
    chk({tag, " R4 pfx_log"}, pfx_log, e_pfx);
    chk({tag, " R4 pfx_flag"}, 128'(pfx_flag), 128'(e_pb));
    chk({tag, " R7/R8 status_set"}, 128'(status_set), 128'(e_reas));
    chk({tag, " R5/R12 hlo_req"}, 128'(hlo_req), 128'(e_ovf));
  endtask

  function automatic logic [31:0] rbit();
    int r = $urandom_range(0, 11);
    return 32'h1 << ((r < 2) ? 4 + r : 10 + r);
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset fep", 128'(fep), 0);
    chk("R11 reset hdr", hdr_log, 0);
    chk("R11 reset pfx", pfx_log, 0);
    chk("R11 reset flags", 128'({pfx_flag, hlo_req, status_set}), 0);
    @(negedge clk); rst = 0;
    // first error logged with header and prefix
    step("R2", 1, 32'h0000_1000, 1, 1, 1, 1, 0, 0);
    // two-hot and unsupported status ignored
    step("R1", 1, 32'h0000_3000, 1, 1, 1, 1, 0, 0);
    step("R1", 1, 32'h0000_0001, 1, 1, 1, 1, 0, 0);
    // fill queue, then overflow
    for (int i = 13; i <= 16; i++) step("R5", 1, 32'h1 << i, 1, 1, 1, 1, 0, 0);
    step("R5", 1, 32'h0002_0000, 1, 1, 1, 1, 0, 0);
    step("R12", 0, 0, 0, 0, 1, 1, 0, 0);
    // clearing the first bit pops the oldest
    step("R7", 0, 0, 0, 0, 1, 1, 1, 32'h0000_1000);
    // write leaving first bit set re-asserts queue bits
    step("R8", 0, 0, 0, 0, 1, 0, 1, 32'h0000_C000);
    // flush with recording disabled, then clear
    step("R9", 0, 0, 0, 0, 0, 1, 1, 32'h0000_0100);
    step("R6", 0, 0, 0, 0, 1, 1, 1, 32'h0000_2000);
    // header invalid and prefix without capability
    step("R3", 1, 32'h0000_0010, 0, 1, 1, 0, 0, 0);
    step("R10", 1, 32'h0000_0020, 1, 1, 1, 1, 0, 0);
    // write popping while an event arrives: event queued
    step("R10", 1, 32'h0010_0000, 1, 0, 1, 1, 1, 32'h0000_0010);
    // write clearing with empty queue while event arrives: event logged
    step("R10", 0, 0, 0, 0, 1, 1, 1, 32'h0000_0020);
    step("R10", 1, 32'h0020_0000, 1, 1, 1, 1, 1, 32'h0010_0000);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic v, wr, me;
      logic [31:0] st, cb;
      v  = ($urandom_range(0, 1) == 1);
      st = ($urandom_range(0, 6) == 0) ? $urandom : rbit();
      me = ($urandom_range(0, 9) != 0);
      wr = ($urandom_range(0, 3) == 0);
      cb = ($urandom_range(0, 1) == 1) ? (32'h1 << e_fep) : ($urandom & $urandom);
      step("R10", v, st, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           me, $urandom_range(0, 9) < 7, wr, cb);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule